// File: doc/BRIEF.md
# Gather/Scatter Micro-op Sequencer

This block takes one predicated vector gather load or scatter store and expands it into a stream of micro-ops. A request gives the vector length code, the element size as a log2 byte count, a load/store select, a first-fault select, an addressing mode and the register numbers. The block computes the element count and issues one micro-op per element in ascending index order. Each micro-op goes out over a valid/ready handshake with its kind, index, total count and sequencing flags.

A load starts with a copy micro-op. The copy moves the address-source vector into a hidden auxiliary register, so a destination that aliases the address vector cannot corrupt later elements. The element micro-ops of a load then take their addresses from that hidden copy. A first-fault load ends with a writeback micro-op. A store with first-fault set is refused: the block raises an error pulse and issues nothing. The request port accepts a new instruction in the same cycle that the final micro-op of the previous one is handed off, so instructions follow each other without a bubble.

Top module: `gs_uop_seq`

## Requirements
- R1: Every micro-op carries the element count ((len+1)*16) >> esz on `uop_cnt_o`, where `req_esz_i` is log2 of the element size in bytes (0 to 3).
- R2: A store (`req_load_i`=0) issues exactly count micro-ops, all of kind 1 (element).
- R3: A load without first-fault issues count+1 micro-ops: one micro-op of kind 0 (copy), then the element micro-ops.
- R4: A first-fault load issues count+2 micro-ops: the copy, the element micro-ops, then one micro-op of kind 2 (writeback).
- R5: Element micro-ops are issued with `uop_idx_o` running 0 to count-1 in ascending order, and every micro-op carries the request's first-fault flag on `uop_ff_o`. Copy and writeback micro-ops show index 0.
- R6: `uop_vsrc_o` names the address vector: the base register when `req_mode_i`=0 (vector plus immediate) and the offset register when `req_mode_i`=1 (scalar plus vector). `uop_aux_o` is 1 only on load element micro-ops, which read the hidden copy. The copy micro-op and store element micro-ops show 0.
- R7: Only the first micro-op of an instruction has `uop_first_o` set, and only the final one has `uop_last_o` set. Every other micro-op has `uop_dcommit_o` set, and the final one has it clear.
- R8: A request with `req_load_i`=0 and `req_ff_i`=1 is accepted and issues no micro-op. `err_o` is 1 for the single cycle after the acceptance. A request that is not refused leaves `err_o` at 0.
- R9: In mode 1, element micro-ops pass on the 32-bit, signed and scaled offset bits unchanged. In mode 0, and on copy and writeback micro-ops, these bits are 0.
- R10: `req_ready_o` is 1 when no instruction is in progress, and also in the cycle its final micro-op is handed off. It is 0 in the cycle after a valid request is accepted. While `uop_valid_o`=1 and `uop_ready_i`=0, the outputs hold.
- R11: `uop_dst_o`, `uop_pred_o` and `uop_base_o` repeat the request's destination, predicate and base register numbers on every micro-op of the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted when valid |
| req_len_i | input | LEN_W | Vector length code; register size (len+1)*16 bytes |
| req_esz_i | input | 2 | log2 of element size in bytes |
| req_load_i | input | 1 | 1 = gather load, 0 = scatter store |
| req_ff_i | input | 1 | First-fault select |
| req_mode_i | input | 1 | 0 = vector plus immediate, 1 = scalar plus vector |
| req_dst_i | input | REG_W | Data vector register |
| req_pred_i | input | PRED_W | Governing predicate register |
| req_base_i | input | REG_W | Base register (vector in mode 0, scalar in mode 1) |
| req_ofs_i | input | REG_W | Offset vector register (mode 1) |
| req_ofs32_i | input | 1 | Offsets are 32-bit |
| req_ofs_sgn_i | input | 1 | Offsets are signed |
| req_ofs_scl_i | input | 1 | Offsets are scaled by element size |
| err_o | output | 1 | One-cycle pulse for a refused request |
| uop_valid_o | output | 1 | Micro-op present |
| uop_ready_i | input | 1 | Downstream takes micro-op |
| uop_kind_o | output | 2 | 0 copy, 1 element, 2 writeback |
| uop_idx_o | output | CNT_W | Element index |
| uop_cnt_o | output | CNT_W | Element count |
| uop_ff_o | output | 1 | First-fault flag |
| uop_first_o | output | 1 | First micro-op of instruction |
| uop_last_o | output | 1 | Final micro-op of instruction |
| uop_dcommit_o | output | 1 | Delayed commit |
| uop_aux_o | output | 1 | Address vector read from hidden copy |
| uop_vsrc_o | output | REG_W | Architectural address vector register |
| uop_base_o | output | REG_W | Base register number |
| uop_dst_o | output | REG_W | Data vector register |
| uop_pred_o | output | PRED_W | Predicate register |
| uop_ofs32_o | output | 1 | Offset 32-bit bit |
| uop_ofs_sgn_o | output | 1 | Offset signed bit |
| uop_ofs_scl_o | output | 1 | Offset scaled bit |

## Verification
Two things can happen in one cycle: the hand-off of the final micro-op of one instruction and the acceptance of the next request. The bench provokes this by issuing requests back to back with downstream ready both held high and toggled. The scoreboard must then see the new instruction's first micro-op, with its first flag, right after the old one's last flag, with no gap and no lost or repeated micro-op. A refused first-fault store is also placed directly behind such a hand-off. There the bench checks that the error pulse appears and that nothing enters the micro-op stream.

// File: rtl/gs_uop_pkg.sv
package gs_uop_pkg;
  typedef enum logic [1:0] {
    UOP_COPY = 2'd0,
    UOP_ELEM = 2'd1,
    UOP_WB   = 2'd2
  } uop_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_COPY = 2'd1,
    ST_ELEM = 2'd2,
    ST_WB   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/gs_elem_count.sv
module gs_elem_count #(
  parameter int LEN_W = 4,
  localparam int CNT_W = LEN_W + 5
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic [1:0]       esz_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] bytes;
  always_comb begin
    bytes = (CNT_W'(len_i) + CNT_W'(1)) << 4;
    cnt_o = bytes >> esz_i;
  end
endmodule

// File: rtl/gs_uop_fsm.sv
module gs_uop_fsm
  import gs_uop_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             start_load_i,
  input  logic             ff_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             fire_i,
  output seq_state_e       state_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             first_o,
  output logic             last_o
);
  logic at_end;
  assign at_end = (idx_o == cnt_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= ST_IDLE;
      idx_o   <= '0;
      first_o <= 1'b0;
    end else if (start_i) begin
      state_o <= start_load_i ? ST_COPY : ST_ELEM;
      idx_o   <= '0;
      first_o <= 1'b1;
    end else if (fire_i) begin
      first_o <= 1'b0;
      unique case (state_o)
        ST_COPY: state_o <= ST_ELEM;
        ST_ELEM: begin
          if (at_end) state_o <= ff_i ? ST_WB : ST_IDLE;
          else        idx_o   <= idx_o + CNT_W'(1);
        end
        ST_WB:   state_o <= ST_IDLE;
        default: state_o <= ST_IDLE;
      endcase
    end
  end

  assign last_o = (state_o == ST_WB) || (state_o == ST_ELEM && at_end && !ff_i);
endmodule

// File: rtl/gs_uop_seq.sv
module gs_uop_seq
  import gs_uop_pkg::*;
#(
  parameter int LEN_W  = 4,
  parameter int REG_W  = 5,
  parameter int PRED_W = 4,
  localparam int CNT_W = LEN_W + 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [1:0]        req_esz_i,
  input  logic              req_load_i,
  input  logic              req_ff_i,
  input  logic              req_mode_i,
  input  logic [REG_W-1:0]  req_dst_i,
  input  logic [PRED_W-1:0] req_pred_i,
  input  logic [REG_W-1:0]  req_base_i,
  input  logic [REG_W-1:0]  req_ofs_i,
  input  logic              req_ofs32_i,
  input  logic              req_ofs_sgn_i,
  input  logic              req_ofs_scl_i,
  output logic              err_o,
  output logic              uop_valid_o,
  input  logic              uop_ready_i,
  output logic [1:0]        uop_kind_o,
  output logic [CNT_W-1:0]  uop_idx_o,
  output logic [CNT_W-1:0]  uop_cnt_o,
  output logic              uop_ff_o,
  output logic              uop_first_o,
  output logic              uop_last_o,
  output logic              uop_dcommit_o,
  output logic              uop_aux_o,
  output logic [REG_W-1:0]  uop_vsrc_o,
  output logic [REG_W-1:0]  uop_base_o,
  output logic [REG_W-1:0]  uop_dst_o,
  output logic [PRED_W-1:0] uop_pred_o,
  output logic              uop_ofs32_o,
  output logic              uop_ofs_sgn_o,
  output logic              uop_ofs_scl_o
);
  logic [CNT_W-1:0]  new_cnt, h_cnt, idx;
  logic              h_load, h_ff, h_mode, h_o32, h_osg, h_osc;
  logic [REG_W-1:0]  h_dst, h_base, h_ofs;
  logic [PRED_W-1:0] h_pred;
  logic              accept, refuse, start, fire, first, last, is_elem;
  seq_state_e        state;

  gs_elem_count #(.LEN_W(LEN_W)) u_cnt (
    .len_i (req_len_i),
    .esz_i (req_esz_i),
    .cnt_o (new_cnt)
  );

  assign fire   = uop_valid_o && uop_ready_i;
  assign accept = req_valid_i && req_ready_o;
  assign refuse = !req_load_i && req_ff_i;
  assign start  = accept && !refuse;
  // next request may enter on the hand-off of the final micro-op
  assign req_ready_o = (state == ST_IDLE) || (fire && last);

  gs_uop_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .start_load_i (req_load_i),
    .ff_i         (h_ff),
    .cnt_i        (h_cnt),
    .fire_i       (fire),
    .state_o      (state),
    .idx_o        (idx),
    .first_o      (first),
    .last_o       (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o  <= 1'b0;
      h_cnt  <= '0;
      h_load <= 1'b0;
      h_ff   <= 1'b0;
      h_mode <= 1'b0;
      h_o32  <= 1'b0;
      h_osg  <= 1'b0;
      h_osc  <= 1'b0;
      h_dst  <= '0;
      h_base <= '0;
      h_ofs  <= '0;
      h_pred <= '0;
    end else begin
      err_o <= accept && refuse;
      if (start) begin
        h_cnt  <= new_cnt;
        h_load <= req_load_i;
        h_ff   <= req_ff_i;
        h_mode <= req_mode_i;
        h_o32  <= req_ofs32_i;
        h_osg  <= req_ofs_sgn_i;
        h_osc  <= req_ofs_scl_i;
        h_dst  <= req_dst_i;
        h_base <= req_base_i;
        h_ofs  <= req_ofs_i;
        h_pred <= req_pred_i;
      end
    end
  end

  assign is_elem = (state == ST_ELEM);

  always_comb begin
    unique case (state)
      ST_COPY: uop_kind_o = UOP_COPY;
      ST_WB:   uop_kind_o = UOP_WB;
      default: uop_kind_o = UOP_ELEM;
    endcase
  end

  assign uop_valid_o   = (state != ST_IDLE);
  assign uop_idx_o     = is_elem ? idx : '0;
  assign uop_cnt_o     = h_cnt;
  assign uop_ff_o      = h_ff;
  assign uop_first_o   = first;
  assign uop_last_o    = last;
  assign uop_dcommit_o = !last;
  assign uop_aux_o     = is_elem && h_load;
  assign uop_vsrc_o    = h_mode ? h_ofs : h_base;
  assign uop_base_o    = h_base;
  assign uop_dst_o     = h_dst;
  assign uop_pred_o    = h_pred;
  assign uop_ofs32_o   = is_elem && h_mode && h_o32;
  assign uop_ofs_sgn_o = is_elem && h_mode && h_osg;
  assign uop_ofs_scl_o = is_elem && h_mode && h_osc;
endmodule

// File: rtl/gs_uop_seq_chk.sv
module gs_uop_seq_chk #(
  parameter int CNT_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_ready_o,
  input logic             err_o,
  input logic             uop_valid_o,
  input logic             uop_ready_i,
  input logic [1:0]       uop_kind_o,
  input logic [CNT_W-1:0] uop_idx_o,
  input logic [CNT_W-1:0] uop_cnt_o,
  input logic             uop_ff_o,
  input logic             uop_first_o,
  input logic             uop_last_o
);
  logic fire;
  assign fire = uop_valid_o && uop_ready_i;

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && !uop_ready_i |=> uop_valid_o && $stable(uop_kind_o)
      && $stable(uop_idx_o) && $stable(uop_last_o));

  assert_ready_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o && uop_valid_o |-> uop_ready_i && uop_last_o);

  assert_next_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && uop_last_o |=> !uop_valid_o || uop_first_o);

  assert_idx_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && uop_kind_o == 2'd1 && (uop_idx_o + CNT_W'(1)) != uop_cnt_o
      |=> uop_kind_o == 2'd1 && uop_idx_o == $past(uop_idx_o) + CNT_W'(1));

  assert_wb_tail_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && uop_kind_o == 2'd2 |-> uop_ff_o && uop_last_o);

  assert_copy_head_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && uop_kind_o == 2'd0 |-> uop_first_o);

  assert_err_silent_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !uop_valid_o);
endmodule

bind gs_uop_seq gs_uop_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .err_o       (err_o),
  .uop_valid_o (uop_valid_o),
  .uop_ready_i (uop_ready_i),
  .uop_kind_o  (uop_kind_o),
  .uop_idx_o   (uop_idx_o),
  .uop_cnt_o   (uop_cnt_o),
  .uop_ff_o    (uop_ff_o),
  .uop_first_o (uop_first_o),
  .uop_last_o  (uop_last_o)
);

// File: tb/tb_gs_uop_seq.sv
module tb_gs_uop_seq;
  localparam int CW = 9;

  typedef struct packed {
    logic [1:0]    kind;
    logic [CW-1:0] idx;
    logic [CW-1:0] cnt;
    logic          ff;
    logic          first;
    logic          last;
    logic          dcm;
    logic          aux;
    logic [4:0]    vsrc;
    logic [4:0]    base;
    logic [4:0]    dst;
    logic [3:0]    pred;
    logic [2:0]    ob;
  } exp_t;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic req_valid = 0, req_load = 0, req_ff = 0, req_mode = 0;
  logic [3:0] req_len = 0, req_pred = 0;
  logic [1:0] req_esz = 0;
  logic [4:0] req_dst = 0, req_base = 0, req_ofs = 0;
  logic [2:0] req_ob = 0;
  logic uop_ready = 1, stall_en = 0;

  logic req_ready, err, uv, uff, ufirst, ulast, udcm, uaux, o32, osg, osc;
  logic [1:0] ukind;
  logic [CW-1:0] uidx, ucnt;
  logic [4:0] uvsrc, ubase, udst;
  logic [3:0] upred;

  gs_uop_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_len_i(req_len), .req_esz_i(req_esz), .req_load_i(req_load), .req_ff_i(req_ff),
    .req_mode_i(req_mode), .req_dst_i(req_dst), .req_pred_i(req_pred),
    .req_base_i(req_base), .req_ofs_i(req_ofs), .req_ofs32_i(req_ob[2]),
    .req_ofs_sgn_i(req_ob[1]), .req_ofs_scl_i(req_ob[0]), .err_o(err),
    .uop_valid_o(uv), .uop_ready_i(uop_ready), .uop_kind_o(ukind), .uop_idx_o(uidx),
    .uop_cnt_o(ucnt), .uop_ff_o(uff), .uop_first_o(ufirst), .uop_last_o(ulast),
    .uop_dcommit_o(udcm), .uop_aux_o(uaux), .uop_vsrc_o(uvsrc), .uop_base_o(ubase),
    .uop_dst_o(udst), .uop_pred_o(upred), .uop_ofs32_o(o32), .uop_ofs_sgn_o(osg),
    .uop_ofs_scl_o(osc)
  );

  int n_chk = 0, n_bad = 0;
  exp_t q[$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // downstream ready: free-running or toggled
  initial begin
    int c = 0;
    forever begin
      @(posedge clk); #1;
      c++;
      uop_ready = stall_en ? (c % 3 != 0) : 1'b1;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && uv && uop_ready) begin
      if (q.size() == 0) begin
        chk("R2/R8 unexpected micro-op", 64'(ukind), 64'h3);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk("R2/R3/R4 kind", 64'(ukind), 64'(e.kind));
        chk("R5 index", 64'(uidx), 64'(e.idx));
        chk("R1 count", 64'(ucnt), 64'(e.cnt));
        chk("R5 ff flag", 64'(uff), 64'(e.ff));
        chk("R7 first/last/dcommit", 64'({ufirst, ulast, udcm}), 64'({e.first, e.last, e.dcm}));
        chk("R6 aux/vsrc", 64'({uaux, uvsrc}), 64'({e.aux, e.vsrc}));
        chk("R11 base/dst/pred", 64'({ubase, udst, upred}), 64'({e.base, e.dst, e.pred}));
        chk("R9 offset bits", 64'({o32, osg, osc}), 64'(e.ob));
      end
    end
  end

  task automatic send(input logic ld, input logic ff, input logic md, input logic [3:0] len,
                      input logic [1:0] esz, input logic [4:0] dst, input logic [3:0] pr,
                      input logic [4:0] bs, input logic [4:0] of, input logic [2:0] ob);
    int cnt;
    logic bad;
    exp_t e;
    bad = !ld && ff;
    cnt = ((int'(len) + 1) * 16) >> esz;
    if (!bad) begin
      e = '0;
      e.cnt = CW'(cnt); e.ff = ff; e.vsrc = md ? of : bs;
      e.base = bs; e.dst = dst; e.pred = pr;
      if (ld) begin
        e.kind = 2'd0; e.first = 1; e.last = 0; e.dcm = 1;
        q.push_back(e);
      end
      for (int i = 0; i < cnt; i++) begin
        e.kind = 2'd1; e.idx = CW'(i);
        e.first = !ld && i == 0;
        e.last = (i == cnt - 1) && !ff;
        e.dcm = !e.last; e.aux = ld; e.ob = md ? ob : 3'b0;
        q.push_back(e);
      end
      if (ff) begin
        e.kind = 2'd2; e.idx = 0; e.first = 0; e.last = 1; e.dcm = 0; e.aux = 0; e.ob = 0;
        q.push_back(e);
      end
    end
    @(posedge clk); #1;
    req_valid = 1; req_load = ld; req_ff = ff; req_mode = md; req_len = len;
    req_esz = esz; req_dst = dst; req_pred = pr; req_base = bs; req_ofs = of; req_ob = ob;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 0;
    @(negedge clk);
    chk("R8 error pulse", 64'(err), 64'(bad));
    if (!bad) chk("R10 ready low after accept", 64'(req_ready), 64'h0);
  endtask

  task automatic drain();
    int t = 0;
    while (q.size() != 0 && t < 5000) begin
      @(negedge clk); t++;
    end
    repeat (3) @(negedge clk);
    chk("R2/R3/R4 all expected micro-ops seen", 64'(q.size()), 64'h0);
    chk("R10 ready when idle", 64'(req_ready), 64'h1);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected<=100000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("reset valid R10", 64'(uv), 64'h0);
    chk("reset ready R10", 64'(req_ready), 64'h1);
    chk("reset err R8", 64'(err), 64'h0);
    rst_n = 1;

    // R2 store, vector+imm, 4 elements
    send(0, 0, 0, 4'd0, 2'd2, 5'd3, 4'd1, 5'd9, 5'd11, 3'b111);
    // R3 load aliasing base and destination, 4 elements
    send(1, 0, 0, 4'd1, 2'd3, 5'd7, 4'd2, 5'd7, 5'd12, 3'b000);
    // R4 first-fault load, scalar+vector, R9 offset bits
    send(1, 1, 1, 4'd0, 2'd2, 5'd4, 4'd3, 5'd20, 5'd21, 3'b101);
    // R8 refused store right behind a hand-off
    send(0, 1, 0, 4'd2, 2'd0, 5'd5, 4'd4, 5'd6, 5'd8, 3'b000);
    drain();

    stall_en = 1;
    // R9 store scalar+vector, 2 elements, stalls
    send(0, 0, 1, 4'd0, 2'd3, 5'd31, 4'd15, 5'd1, 5'd2, 3'b010);
    // R4 first-fault load, minimum count
    send(1, 1, 0, 4'd0, 2'd3, 5'd10, 4'd5, 5'd13, 5'd14, 3'b011);
    // R3 load scalar+vector
    send(1, 0, 1, 4'd2, 2'd1, 5'd16, 4'd6, 5'd17, 5'd18, 3'b110);
    send(0, 1, 1, 4'd0, 2'd0, 5'd1, 4'd0, 5'd1, 5'd1, 3'b111);
    drain();

    stall_en = 0;
    // R1 largest count: 256 byte elements
    send(1, 0, 0, 4'd15, 2'd0, 5'd0, 4'd7, 5'd2, 5'd3, 3'b000);
    send(0, 0, 1, 4'd15, 2'd3, 5'd8, 4'd8, 5'd9, 5'd10, 3'b001);
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule